// File: doc/BRIEF.md
# Atomic SPI Header Loader

This block sits between a register interface and the transmit byte queue of an SPI peripheral. A single write to one of several header ports loads a whole header of one to four bytes into the queue as one indivisible operation. Port k carries k+1 bytes. The bytes enter the queue least significant byte first, on consecutive cycles, and nothing else can interleave with them. A write is either taken whole or dropped whole.

Whether a header write is taken depends on the chip-select input, on a small status register and on the free space the queue reports. The status register has four bits. The gating bit chooses between blocking and unblocked policies. The enable bit arms the header. The committed bit shows that chip select went active while the header was armed. The sticky ignored bit records any dropped header write. Software clears committed and ignored by writing zero to them.

Top module: `hdr_atomic_ctrl`

## Requirements
- R1: A write on port k (k = 0 to NUM_PORTS-1) that is taken pushes k+1 bytes. The pushes fall on the k+1 cycles that follow the write edge, with `q_push_o` high on each of them. The i-th push carries bits [8i+7:8i] of `hdr_data_i`.
- R2: When several header strobes are high in one cycle, only the highest-numbered port is acted on. The others are discarded and do not touch the ignored bit.
- R3: In blocking mode (`ctl_o[0]`=1), a header write while `cs_n_i` is low pushes nothing and sets the ignored bit (`ctl_o[3]`). Header writes never change the enable bit (`ctl_o[1]`) in this mode.
- R4: In unblocked mode (`ctl_o[0]`=0), every header write sets the enable bit at the write edge, whether or not the write is taken.
- R5: The committed bit (`ctl_o[2]`) sets at an edge where `cs_n_i` is low and enable is already 1, or is being set by that same edge. It never sets while `cs_n_i` is high.
- R6: In unblocked mode, a header write while committed is 0 is taken whatever the state of `cs_n_i`. A header write while committed is 1 is dropped and sets the ignored bit.
- R7: A control write (`ctl_we_i`) loads gating and enable from `ctl_wdata_i[0]` and `ctl_wdata_i[1]`. A zero in `ctl_wdata_i[2]` or `ctl_wdata_i[3]` clears committed or ignored, and a one leaves that bit as it is. A hardware set in the same cycle wins over the clear.
- R8: A header write needing more bytes than `q_free_i` pushes nothing and sets the ignored bit. A write that exactly fills the space is taken.
- R9: A header write arriving while an earlier header is still being pushed is dropped and sets the ignored bit. The earlier header completes unchanged.
- R10: After reset, `ctl_o` is 0, so the block is in unblocked mode, and `q_push_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| hdr_we_i | input | NUM_PORTS | Header write strobes; bit k carries k+1 bytes |
| hdr_data_i | input | 8*NUM_PORTS | Header data, byte 0 in the low bits |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data {ignored, committed, enable, gating} |
| ctl_o | output | 4 | Control/status {ignored, committed, enable, gating} |
| q_free_i | input | FREE_W | Free byte slots in the transmit queue |
| q_push_o | output | 1 | Byte push to the transmit queue |
| q_byte_o | output | 8 | Byte being pushed |

## Verification
The bench builds the block with its defaults: four header ports and a 5-bit free-space count. With these values each header length from one to four bytes can be driven against free-space values of zero, exactly enough and plenty, so both the exact-fit and the one-short overflow boundary are reachable. The small depth keeps the back-to-back case, where a write lands while a four-byte push is still running, within a few cycles. Both gating policies are walked through chip-select falls that come before and after the first header write.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  typedef struct packed {
    logic ign;
    logic commit;
    logic en;
    logic gate;
  } hdr_ctl_t;

  function automatic int port_bytes(input int k);
    return k + 1;
  endfunction
endpackage

// File: rtl/hdr_port_arb.sv
module hdr_port_arb #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 3
) (
  input  logic [NUM_PORTS-1:0] we_i,
  output logic                 any_o,
  output logic [CNT_W-1:0]     nbytes_o
);
  // highest-numbered port wins
  always_comb begin
    nbytes_o = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (we_i[k]) nbytes_o = CNT_W'(hdr_pkg::port_bytes(k));
    end
  end

  assign any_o = |we_i;
endmodule

// File: rtl/hdr_policy.sv
module hdr_policy
  import hdr_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int FREE_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             any_wr_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             busy_i,
  input  logic [FREE_W-1:0] q_free_i,
  input  logic             ctl_we_i,
  input  hdr_ctl_t         ctl_wdata_i,
  output logic             accept_o,
  output hdr_ctl_t         ctl_o
);
  localparam int CMP_W = (CNT_W > FREE_W) ? CNT_W + 1 : FREE_W + 1;

  hdr_ctl_t st_q, st_d;
  logic cs_low, blocking, no_room, drop, auto_en;

  always_comb begin
    cs_low   = ~cs_n_i;
    blocking = st_q.gate;
    no_room  = CMP_W'(nbytes_i) > CMP_W'(q_free_i);
    drop     = (blocking & cs_low) | (~blocking & st_q.commit) | no_room | busy_i;
    accept_o = any_wr_i & ~drop;
    auto_en  = any_wr_i & ~blocking;

    st_d = st_q;
    if (ctl_we_i) begin
      st_d.gate = ctl_wdata_i.gate;
      st_d.en   = ctl_wdata_i.en;
      if (!ctl_wdata_i.commit) st_d.commit = 1'b0;
      if (!ctl_wdata_i.ign)    st_d.ign    = 1'b0;
    end
    if (auto_en)                          st_d.en     = 1'b1;
    if (cs_low && (st_q.en || auto_en))   st_d.commit = 1'b1;
    if (any_wr_i && drop)                 st_d.ign    = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign ctl_o = st_q;
endmodule

// File: rtl/hdr_pusher.sv
module hdr_pusher #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [CNT_W-1:0]       nbytes_i,
  input  logic [8*NUM_PORTS-1:0] data_i,
  output logic                   busy_o,
  output logic                   push_o,
  output logic [7:0]             byte_o
);
  localparam int DATA_W = 8 * NUM_PORTS;

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= nbytes_i;
    end else if (cnt_q != '0) begin
      sh_q  <= sh_q >> 8;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = cnt_q != '0;
  assign push_o = busy_o;
  assign byte_o = sh_q[7:0];
endmodule

// File: rtl/hdr_atomic_ctrl.sv
module hdr_atomic_ctrl
  import hdr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FREE_W    = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_n_i,
  input  logic [NUM_PORTS-1:0]   hdr_we_i,
  input  logic [8*NUM_PORTS-1:0] hdr_data_i,
  input  logic                   ctl_we_i,
  input  logic [3:0]             ctl_wdata_i,
  output logic [3:0]             ctl_o,
  input  logic [FREE_W-1:0]      q_free_i,
  output logic                   q_push_o,
  output logic [7:0]             q_byte_o
);
  localparam int CNT_W = $clog2(NUM_PORTS + 1);

  logic             any_wr, accept, busy;
  logic [CNT_W-1:0] nbytes;
  hdr_ctl_t         st;

  hdr_port_arb #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_arb (
    .we_i     (hdr_we_i),
    .any_o    (any_wr),
    .nbytes_o (nbytes)
  );

  hdr_policy #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_pol (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_n_i      (cs_n_i),
    .any_wr_i    (any_wr),
    .nbytes_i    (nbytes),
    .busy_i      (busy),
    .q_free_i    (q_free_i),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (hdr_ctl_t'(ctl_wdata_i)),
    .accept_o    (accept),
    .ctl_o       (st)
  );

  hdr_pusher #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_push (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .nbytes_i (nbytes),
    .data_i   (hdr_data_i),
    .busy_o   (busy),
    .push_o   (q_push_o),
    .byte_o   (q_byte_o)
  );

  assign ctl_o = st;
endmodule

// File: rtl/hdr_atomic_chk.sv
module hdr_atomic_chk #(
  parameter int NUM_PORTS = 4,
  parameter int FREE_W    = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cs_n_i,
  input logic [NUM_PORTS-1:0] hdr_we_i,
  input logic                 ctl_we_i,
  input logic [3:0]           ctl_wdata_i,
  input logic [3:0]           ctl_o,
  input logic [FREE_W-1:0]    q_free_i,
  input logic                 q_push_o
);
  a_r5_commit_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_o[2]) |-> $past(cs_n_i) == 1'b0);

  a_r3_blocked_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[0] && !cs_n_i && (|hdr_we_i) && !q_push_o) |=> !q_push_o);

  a_r6_committed_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[0] && ctl_o[2] && (|hdr_we_i) && !q_push_o) |=> !q_push_o);

  a_r8_no_room_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|hdr_we_i) && !q_push_o && q_free_i == '0) |=> !q_push_o);

  a_r4_auto_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_o[0] && (|hdr_we_i)) |=> ctl_o[1]);

  a_r7_ignored_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[3] && !(ctl_we_i && !ctl_wdata_i[3])) |=> ctl_o[3]);

  a_r3_blocked_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o[0] && !ctl_we_i) |=> $stable(ctl_o[1]));
endmodule

bind hdr_atomic_ctrl hdr_atomic_chk #(.NUM_PORTS(NUM_PORTS), .FREE_W(FREE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_i      (cs_n_i),
  .hdr_we_i    (hdr_we_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .ctl_o       (ctl_o),
  .q_free_i    (q_free_i),
  .q_push_o    (q_push_o)
);

// File: tb/hdr_atomic_ctrl_test.sv
module hdr_atomic_ctrl_test;
  localparam int NP = 4;
  localparam int FW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_n_i = 1'b1;
  logic [NP-1:0] hdr_we_i = '0;
  logic [31:0]   hdr_data_i = '0;
  logic          ctl_we_i = 1'b0;
  logic [3:0]    ctl_wdata_i = '0;
  logic [3:0]    ctl_o;
  logic [FW-1:0] q_free_i = 5'd16;
  logic          q_push_o;
  logic [7:0]    q_byte_o;

  int errs = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  hdr_atomic_ctrl #(.NUM_PORTS(NP), .FREE_W(FW)) uut (.*);

  typedef struct packed {
    logic [1:0]  port;
    logic [31:0] data;
    logic [4:0]  free;
    logic [2:0]  n;
    logic        ign;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd3, 32'h44332211, 5'd16, 3'd4, 1'b0},
    '{2'd2, 32'hAABBCCDD, 5'd3,  3'd3, 1'b0},
    '{2'd1, 32'h12345678, 5'd2,  3'd2, 1'b0},
    '{2'd0, 32'h000000A5, 5'd1,  3'd1, 1'b0},
    '{2'd3, 32'hDEADBEEF, 5'd3,  3'd0, 1'b1},
    '{2'd1, 32'h0000C3C3, 5'd1,  3'd0, 1'b1},
    '{2'd0, 32'h0000005A, 5'd0,  3'd0, 1'b1},
    '{2'd2, 32'h00FF00FF, 5'd31, 3'd3, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic g, input logic e, input logic c, input logic i);
    @(negedge clk_i);
    ctl_we_i = 1'b1;
    ctl_wdata_i = {i, c, e, g};
    @(negedge clk_i);
    ctl_we_i = 1'b0;
  endtask

  // drive one strobe set, then count pushes and check byte order
  task automatic run_hdr(input logic [NP-1:0] we, input logic [31:0] d,
                         input int exp_n, input string req);
    int n;
    @(negedge clk_i);
    hdr_we_i = we;
    hdr_data_i = d;
    @(negedge clk_i);
    hdr_we_i = '0;
    n = 0;
    for (int i = 0; i < 6; i++) begin
      if (q_push_o) begin
        check(req, {24'd0, q_byte_o}, (d >> (8 * n)) & 32'hFF);
        n++;
      end
      @(negedge clk_i);
    end
    check(req, n, exp_n);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", {28'd0, ctl_o}, 32'h0);
    check("R10", {31'd0, q_push_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table: blocking mode, cs high, enable 0
    for (int v = 0; v < 8; v++) begin
      write_ctl(1'b1, 1'b0, 1'b0, 1'b0);
      q_free_i = VECS[v].free;
      run_hdr(NP'(1 << VECS[v].port), VECS[v].data, int'(VECS[v].n),
              (VECS[v].n == 0) ? "R8" : "R1");
      check("R8", {31'd0, ctl_o[3]}, {31'd0, VECS[v].ign});
    end
    q_free_i = 5'd16;

    // R2 simultaneous strobes: port 3 wins, no ignore
    write_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    run_hdr(4'b1001, 32'h0A0B0C0D, 4, "R2");
    check("R2", {31'd0, ctl_o[3]}, 32'h0);

    // R3 blocking, cs low: drop, ignored set, enable untouched
    cs_n_i = 1'b0;
    run_hdr(4'b0010, 32'h00001111, 0, "R3");
    check("R3", {28'd0, ctl_o}, 32'h9);
    cs_n_i = 1'b1;

    // R9 write during running push
    write_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    hdr_we_i = 4'b1000;
    hdr_data_i = 32'h87654321;
    begin
      int n;
      n = 0;
      @(negedge clk_i);
      hdr_we_i = 4'b0001;
      hdr_data_i = 32'h000000EE;
      for (int i = 0; i < 6; i++) begin
        if (q_push_o) begin
          check("R9", {24'd0, q_byte_o}, (32'h87654321 >> (8 * n)) & 32'hFF);
          n++;
        end
        @(negedge clk_i);
        hdr_we_i = '0;
      end
      check("R9", n, 4);
    end
    check("R9", {31'd0, ctl_o[3]}, 32'h1);

    // R7 hardware set wins over clear in the same cycle
    write_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", {31'd0, ctl_o[3]}, 32'h0);
    cs_n_i = 1'b0;
    @(negedge clk_i);
    ctl_we_i = 1'b1;
    ctl_wdata_i = 4'b0001;
    hdr_we_i = 4'b0001;
    @(negedge clk_i);
    ctl_we_i = 1'b0;
    hdr_we_i = '0;
    check("R7", {31'd0, ctl_o[3]}, 32'h1);
    cs_n_i = 1'b1;

    // R5 blocking: software enable, commit on cs low only
    write_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk_i);
    check("R5", {31'd0, ctl_o[2]}, 32'h0);
    cs_n_i = 1'b0;
    @(negedge clk_i);
    check("R5", {31'd0, ctl_o[2]}, 32'h1);
    cs_n_i = 1'b1;
    write_ctl(1'b1, 1'b0, 1'b1, 1'b0);
    check("R7", {31'd0, ctl_o[2]}, 32'h1);
    write_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", {31'd0, ctl_o[2]}, 32'h0);

    // unblocked, first write with cs low is taken and commits
    write_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    cs_n_i = 1'b0;
    @(negedge clk_i);
    check("R5", {31'd0, ctl_o[2]}, 32'h0);
    run_hdr(4'b0010, 32'h0000BEEF, 2, "R6");
    check("R6", {28'd0, ctl_o}, 32'h6);
    run_hdr(4'b0001, 32'h00000077, 0, "R6");
    check("R6", {31'd0, ctl_o[3]}, 32'h1);
    cs_n_i = 1'b1;

    // unblocked, write with cs high, commit on cs fall
    write_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    run_hdr(4'b0100, 32'h00332211, 3, "R6");
    check("R4", {28'd0, ctl_o}, 32'h2);
    cs_n_i = 1'b0;
    @(negedge clk_i);
    check("R5", {31'd0, ctl_o[2]}, 32'h1);
    run_hdr(4'b1000, 32'h11111111, 0, "R6");
    check("R6", {31'd0, ctl_o[3]}, 32'h1);
    cs_n_i = 1'b1;

    // R4 dropped write still sets enable
    write_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    q_free_i = 5'd0;
    run_hdr(4'b0001, 32'h00000042, 0, "R4");
    check("R4", {28'd0, ctl_o}, 32'hA);
    q_free_i = 5'd16;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule